// File: doc/BRIEF.md
# SPI Interrupt Aggregator with Keyed Soft Reset

This block sits next to an SPI master controller and turns its events into one interrupt line. Seven event inputs come from the shifter and FIFO logic as one-cycle pulses or as levels. The block records the rising edge of each one in a sticky status bit. A per-source enable register and a single global enable bit then mask these bits to produce a level interrupt. Software clears status bits by writing ones to them. Because of this, writing back a value read from the status register acknowledges exactly the events that were seen.

The same 32-bit register port also has a guarded reset register. Only one key value starts a soft reset. That value drives a reset pulse of fixed length to the SPI core and clears the interrupt status and per-source enables. Any other value written there is dropped. A typical driver enables the transmit-empty source, lets the transfer run, and treats that interrupt as the sign that the last queued word has finished shifting.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset, the global enable, status and source-enable registers read zero, and `irq_out` and `core_rst` are low.
- R2: A rising edge on `evt_in[i]` sets status bit i on the next clock edge. The bit meanings are: 0 mode fault, 1 slave-mode fault, 2 transmit FIFO empty, 3 transmit underrun, 4 receive FIFO full, 5 receive overrun, 6 transmit FIFO half empty. A level that stays high sets its bit only once.
- R3: Status bits stay set until software writes a one to that bit position at offset 0x20. Zero bits in that write leave the status unchanged.
- R4: If a rising edge and a clear for the same bit arrive in the same cycle, the bit stays set.
- R5: The source-enable register at offset 0x28 (bits 6:0) reads back what was written. `irq_out` is high exactly when bit 31 of the global enable register at offset 0x1C is set and at least one status bit has its enable bit set.
- R6: Writing zero to offset 0x28 masks every source, so `irq_out` stays low whatever the status is.
- R7: While global enable bit 31 is clear, `irq_out` is low even when enabled status bits are pending.
- R8: Writing 0x0000000A to offset 0x40 drives `core_rst` high for exactly 4 cycles, starting the cycle after the write. A key write while the pulse is active is ignored.
- R9: Writing any other value to offset 0x40 has no effect. No pulse appears, and status and enable registers are kept.
- R10: A keyed soft reset clears the status and source-enable registers and holds them at zero while `core_rst` is high. The global enable is kept.
- R11: Offset 0x40 and offsets that are not mapped read as zero, and status and enable bits above bit 6 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, valid with reg_sel |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_in | input | 7 | Event inputs from the SPI core |
| irq_out | output | 1 | Level interrupt request |
| core_rst | output | 1 | Soft reset pulse to the SPI core |

## Verification
On every cycle, the assertions check the sticky status rules: a rising edge sets a bit, a write of ones clears it, a set beats a clear in the same cycle, and a bit holds when no clear arrives. They also check that the interrupt appears only for enabled, globally allowed sources, that the reset pulse has its exact length and is started only by the key, and that the wipe empties both registers. The bench scenarios are the only place where the read-back values, the combined effect of the bit map and enable masks on a given event pattern, and the retention of registers after a wrong key can be seen.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int SRC_COUNT = 7;

  // Next value of one sticky status bit: wipe dominates, then set beats clear.
  function automatic logic sticky_bit(input logic cur, input logic rise,
                                      input logic clr, input logic wipe);
    return wipe ? 1'b0 : ((cur & ~clr) | rise);
  endfunction

  // Interrupt level from global enable, status and per-source enables.
  function automatic logic irq_any(input logic gie, input logic [31:0] st,
                                   input logic [31:0] en);
    return gie & (|(st & en));
  endfunction

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic [NUM_SRC-1:0] clr_vec,
  input  logic               wipe,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] rise_vec
);
  import spi_irq_pkg::*;

  logic [NUM_SRC-1:0] evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_in;
  end

  assign rise_vec = evt_in & ~evt_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= sticky_bit(status[i], rise_vec[i] & ~wipe,
                                          clr_vec[i], wipe);
    end
  end

endmodule

// File: rtl/soft_reset_gen.sv
module soft_reset_gen #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_hit,
  output logic core_rst,
  output logic wipe
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt;
  logic             busy;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (busy)            cnt <= cnt - 1'b1;
    else if (key_hit)         cnt <= LOAD;
  end

  assign core_rst = busy;
  assign wipe     = busy | key_hit;

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl #(
  parameter int NUM_SRC    = spi_irq_pkg::SRC_COUNT,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4,
  parameter logic [ADDR_W-1:0] OFS_GIE = 8'h1C,
  parameter logic [ADDR_W-1:0] OFS_STS = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_ENA = 8'h28,
  parameter logic [ADDR_W-1:0] OFS_RST = 8'h40,
  parameter logic [DATA_W-1:0] RST_KEY = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic              irq_out,
  output logic              core_rst
);
  import spi_irq_pkg::*;

  localparam int GIE_BIT = DATA_W - 1;

  logic               wr_any, wr_gie, wr_sts, wr_ena, wr_rst;
  logic               key_hit, wipe, gie;
  logic [NUM_SRC-1:0] clr_vec, rise_vec, status, en;

  assign wr_any  = reg_sel & reg_wr;
  assign wr_gie  = wr_any & (reg_addr == OFS_GIE);
  assign wr_sts  = wr_any & (reg_addr == OFS_STS);
  assign wr_ena  = wr_any & (reg_addr == OFS_ENA);
  assign wr_rst  = wr_any & (reg_addr == OFS_RST);
  assign key_hit = wr_rst & (reg_wdata == RST_KEY);
  assign clr_vec = wr_sts ? reg_wdata[NUM_SRC-1:0] : '0;

  irq_src_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .clr_vec(clr_vec),
    .wipe(wipe), .status(status), .rise_vec(rise_vec)
  );

  soft_reset_gen #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk(clk), .rst_n(rst_n), .key_hit(key_hit),
    .core_rst(core_rst), .wipe(wipe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie <= 1'b0;
    else if (wr_gie) gie <= reg_wdata[GIE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (wipe)   en <= '0;
    else if (wr_ena) en <= reg_wdata[NUM_SRC-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_GIE)      reg_rdata[GIE_BIT] = gie;
    else if (reg_addr == OFS_STS) reg_rdata[NUM_SRC-1:0] = status;
    else if (reg_addr == OFS_ENA) reg_rdata[NUM_SRC-1:0] = en;
  end

  assign irq_out = irq_any(gie, 32'(status), 32'(en));

endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
  parameter int NUM_SRC    = 7,
  parameter int RST_CYCLES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] rise_vec,
  input logic [NUM_SRC-1:0] clr_vec,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] en,
  input logic               gie,
  input logic               wipe,
  input logic               key_hit,
  input logic               irq_out,
  input logic               core_rst
);
  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_len <= '0;
    else if (core_rst) hi_len <= hi_len + 16'd1;
    else               hi_len <= '0;
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec != '0 && !wipe) |=> ((status & $past(rise_vec)) == $past(rise_vec))); // R2 R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((status & $past(clr_vec & ~rise_vec)) == '0)); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && clr_vec == '0) |=> ((status & $past(status)) == $past(status))); // R3
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((status & en) != '0)); // R5
  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_out); // R6
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_out); // R7
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst && hi_len != 16'd0) |-> (hi_len == 16'(RST_CYCLES))); // R8
  AST_KEY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> $past(key_hit)); // R9
  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (status == '0 && en == '0)); // R10

endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_vec(rise_vec), .clr_vec(clr_vec),
  .status(status), .en(en), .gie(gie), .wipe(wipe), .key_hit(key_hit),
  .irq_out(irq_out), .core_rst(core_rst)
);

// File: tb/sim_spi_irq_ctrl.sv
`timescale 1ns/1ps
module sim_spi_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  evt_in = '0;
  logic        irq_out, core_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  spi_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_in(evt_in), .irq_out(irq_out), .core_rst(core_rst)
  );

  // {evt, en, gie, clr, exp_status, exp_irq}
  localparam logic [29:0] VEC [7] = '{
    {7'h01, 7'h01, 1'b1, 7'h00, 7'h01, 1'b1},
    {7'h05, 7'h02, 1'b1, 7'h00, 7'h05, 1'b0},
    {7'h7F, 7'h40, 1'b0, 7'h00, 7'h7F, 1'b0},
    {7'h7F, 7'h7F, 1'b1, 7'h7F, 7'h00, 1'b0},
    {7'h24, 7'h04, 1'b1, 7'h04, 7'h20, 1'b0},
    {7'h48, 7'h08, 1'b1, 7'h40, 7'h08, 1'b1},
    {7'h12, 7'h7F, 1'b1, 7'h01, 7'h12, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); evt_in = e;
    @(negedge clk); evt_in = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h1C, d); chk("R1 gie", d, 32'h0);
    rd(8'h20, d); chk("R1 status", d, 32'h0);
    rd(8'h28, d); chk("R1 enable", d, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    chk("R1 core_rst", {31'b0, core_rst}, 32'h0);

    // Vector table: R2 R3 R5 R7
    foreach (VEC[k]) begin
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h1C, {VEC[k][15], 31'b0});
      wr(8'h28, {25'b0, VEC[k][22:16]});
      pulse(VEC[k][29:23]);
      wr(8'h20, {25'b0, VEC[k][14:8]});
      rd(8'h20, d); chk($sformatf("R2/R3 row%0d status", k), d, {25'b0, VEC[k][7:1]});
      chk($sformatf("R5/R7 row%0d irq", k), {31'b0, irq_out}, {31'b0, VEC[k][0]});
    end
    rd(8'h28, d); chk("R5 enable readback", d, 32'h7F);

    // R4 same-cycle set and clear
    wr(8'h20, 32'hFFFF_FFFF);
    pulse(7'h0C);
    @(negedge clk);
    evt_in = 7'h04; reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h0C;
    @(negedge clk);
    evt_in = '0; reg_sel = 1'b0; reg_wr = 1'b0;
    rd(8'h20, d); chk("R4 set beats clear", d, 32'h04);

    // R2 held level sets once
    wr(8'h20, 32'hFFFF_FFFF);
    @(negedge clk); evt_in = 7'h10;
    @(negedge clk);
    rd(8'h20, d); chk("R2 level sets", d, 32'h10);
    wr(8'h20, 32'h10);
    repeat (2) @(negedge clk);
    rd(8'h20, d); chk("R2 held level no reset", d, 32'h0);
    @(negedge clk); evt_in = '0;

    // R6 zero enable masks all
    pulse(7'h7F);
    wr(8'h1C, 32'h8000_0000);
    wr(8'h28, 32'h0);
    chk("R6 masked irq", {31'b0, irq_out}, 32'h0);
    wr(8'h28, 32'h7F);
    chk("R5 irq on enable", {31'b0, irq_out}, 32'h1);

    // R9 wrong key ignored
    wr(8'h40, 32'h0000_000B);
    n = 0;
    repeat (6) begin @(negedge clk); if (core_rst) n++; end
    chk("R9 no pulse", n, 0);
    rd(8'h20, d); chk("R9 status kept", d, 32'h7F);
    rd(8'h28, d); chk("R9 enable kept", d, 32'h7F);
    chk("R9 irq kept", {31'b0, irq_out}, 32'h1);

    // R8 keyed reset pulse length
    wr(8'h40, 32'h0000_000A);
    n = 0;
    while (core_rst && n < 20) begin n++; @(negedge clk); end
    chk("R8 pulse length", n, 4);

    // R10 registers wiped, gie kept
    rd(8'h20, d); chk("R10 status wiped", d, 32'h0);
    rd(8'h28, d); chk("R10 enable wiped", d, 32'h0);
    rd(8'h1C, d); chk("R10 gie kept", d, 32'h8000_0000);
    chk("R10 irq low", {31'b0, irq_out}, 32'h0);

    // R11 unmapped and reset register read zero; upper bits zero
    rd(8'h40, d); chk("R11 reset reg reads zero", d, 32'h0);
    rd(8'h24, d); chk("R11 unmapped zero", d, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, d); chk("R11 enable upper bits", d, 32'h7F);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule